// File: doc/BRIEF.md
# Control Endpoint Handshake Register

This block is the status and control register that firmware and the USB serial engine share for a control endpoint. The CPU side has an 8-bit write port with a write strobe and a combinational read port. The serial-engine side drives five single-cycle event pulses:

- a packet was received;
- a packet was transmitted;
- a protocol error was seen;
- the data phase ended early;
- the status phase completed.

The register holds six flags: receive-ready, transmit-ready, stall request, data-end, forced-stall and setup-end. Each flag has its own set and clear rule.

Firmware uses the flags to pace the transfer. It waits for receive-ready, drains the FIFO, and then acknowledges by writing 1 to a serviced strobe. It loads the IN FIFO and then raises transmit-ready. It marks the last packet with data-end. It requests a stall with the stall bit. When an aborted transfer raises setup-end, the busy output tells firmware to stop touching the FIFO for that transaction until it acknowledges the abort.

All flags update on the rising clock edge that samples the event or write. The read port and busy reflect the new value immediately after that edge.

Top module: `ctl_ep_hsreg`

## Requirements
- R1: After reset every readable bit of the register is 0 and busy is 0.
- R2: Bit 0 (receive-ready) becomes 1 after a received-packet event. It becomes 0 only after a write with bit 6 = 1. Writes with bit 6 = 0 leave it unchanged.
- R3: Bit 1 (transmit-ready) becomes 1 after a write with bit 1 = 1 and becomes 0 after a transmitted-packet event. A write with bit 1 = 0 leaves it unchanged. If the write sets it in the same cycle as the event, the write wins.
- R4: Bit 2 (stall request) takes the value of bit 2 on every write and holds it between writes.
- R5: Bit 3 (data-end) becomes 1 after a write with bit 3 = 1 and becomes 0 after a status-complete event. A write with bit 3 = 0 leaves it unchanged. If the write sets it in the same cycle as the event, the write wins.
- R6: Bit 4 (forced-stall) becomes 1 after a protocol-error event. It becomes 0 after a write with bit 4 = 0. A write with bit 4 = 1 leaves it unchanged.
- R7: Bit 5 (setup-end) becomes 1 after an early-end event. It becomes 0 only after a write with bit 5's strobe, bit 7 = 1. Writes with bit 7 = 0 leave it unchanged.
- R8: Bits 6 and 7 are command strobes that hold no state and always read 0.
- R9: When a hardware set event coincides with a firmware clear of the same flag, the flag ends up 1.
- R10: One write may set firmware bits and fire both strobes together, and each action takes effect as if it were alone.
- R11: busy is 1 exactly when setup-end reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| ev_rx_pkt | input | 1 | Data packet received pulse |
| ev_tx_done | input | 1 | Data packet transmitted pulse |
| ev_proto_err | input | 1 | Protocol error pulse |
| ev_early_end | input | 1 | Data phase ended before full length pulse |
| ev_status_done | input | 1 | Status phase completed pulse |
| busy_o | output | 1 | Stop FIFO access, setup-end pending |

## Verification
A wrong internal flag state is visible on rd_data on the very next read, because the read port is a direct image of the flag registers. A flag that drifts, sticks or loses an event shows up one clock after the offending event or write. A busy output that disagrees with bit 5 shows up in the same cycle. The bench drives every combination of write data, write strobe and the five event pulses against an arithmetic reference and compares every bit after every edge. This catches wrong priorities and write decodes within a single cycle of their cause.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
   localparam int unsigned NFLAG      = 6;
   localparam int unsigned B_RXRDY    = 0;
   localparam int unsigned B_TXRDY    = 1;
   localparam int unsigned B_STALLREQ = 2;
   localparam int unsigned B_DATAEND  = 3;
   localparam int unsigned B_FSTALL   = 4;
   localparam int unsigned B_SETUPEND = 5;
   localparam int unsigned B_SVC_RX   = 6;
   localparam int unsigned B_SVC_SE   = 7;
   localparam int unsigned MIN_DW     = 8;

   typedef logic [NFLAG-1:0] flag_vec_t;

   typedef struct packed {
      logic status_done;
      logic early_end;
      logic proto_err;
      logic tx_done;
      logic rx_pkt;
   } hs_events_t;
endpackage

// File: rtl/ep_hs_decode.sv
module ep_hs_decode
   import ep_hs_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  hs_events_t    ev,
   output flag_vec_t     set_v,
   output flag_vec_t     clr_v
);
   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("ep_hs_decode: DW must be at least 8");
      end
   endgenerate

   logic wr_one_txrdy, wr_one_dataend, wr_svc_rx, wr_svc_se;

   always_comb begin
      wr_one_txrdy   = wr_en & wr_data[B_TXRDY];
      wr_one_dataend = wr_en & wr_data[B_DATAEND];
      wr_svc_rx      = wr_en & wr_data[B_SVC_RX];
      wr_svc_se      = wr_en & wr_data[B_SVC_SE];

      set_v = '0;
      clr_v = '0;

      // receive-ready: hardware sets, serviced strobe clears
      set_v[B_RXRDY]    = ev.rx_pkt;
      clr_v[B_RXRDY]    = wr_svc_rx;
      // transmit-ready: firmware sets, hardware clears
      set_v[B_TXRDY]    = wr_one_txrdy;
      clr_v[B_TXRDY]    = ev.tx_done;
      // stall request: plain firmware bit
      set_v[B_STALLREQ] = wr_en & wr_data[B_STALLREQ];
      clr_v[B_STALLREQ] = wr_en & ~wr_data[B_STALLREQ];
      // data-end: firmware sets, status completion clears
      set_v[B_DATAEND]  = wr_one_dataend;
      clr_v[B_DATAEND]  = ev.status_done;
      // forced-stall: hardware sets, firmware writes 0 to clear
      set_v[B_FSTALL]   = ev.proto_err;
      clr_v[B_FSTALL]   = wr_en & ~wr_data[B_FSTALL];
      // setup-end: hardware sets, serviced strobe clears
      set_v[B_SETUPEND] = ev.early_end;
      clr_v[B_SETUPEND] = wr_svc_se;
   end
endmodule

// File: rtl/ep_hs_flag.sv
module ep_hs_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_pri
         always_comb begin
            if (set_i)      nxt = 1'b1;
            else if (clr_i) nxt = 1'b0;
            else            nxt = q;
         end
      end else begin : g_clr_pri
         always_comb begin
            if (clr_i)      nxt = 1'b0;
            else if (set_i) nxt = 1'b1;
            else            nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/ep_hs_rdmux.sv
module ep_hs_rdmux
   import ep_hs_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  flag_vec_t     flags,
   output logic [DW-1:0] rd_data
);
   localparam int unsigned PAD = DW - NFLAG;

   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("ep_hs_rdmux: DW must be at least 8");
      end
   endgenerate

   // strobe positions and any upper padding read as zero
   always_comb rd_data = {{PAD{1'b0}}, flags};
endmodule

// File: rtl/ctl_ep_hsreg.sv
module ctl_ep_hsreg
   import ep_hs_pkg::*;
#(
   parameter int unsigned DW            = 8,
   parameter logic [5:0]  SET_WINS_MASK = 6'h3F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          ev_rx_pkt,
   input  logic          ev_tx_done,
   input  logic          ev_proto_err,
   input  logic          ev_early_end,
   input  logic          ev_status_done,
   output logic          busy_o
);
   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("ctl_ep_hsreg: DW must be at least 8");
      end
   endgenerate

   hs_events_t ev;
   flag_vec_t  set_v, clr_v, flags;

   always_comb begin
      ev.rx_pkt      = ev_rx_pkt;
      ev.tx_done     = ev_tx_done;
      ev.proto_err   = ev_proto_err;
      ev.early_end   = ev_early_end;
      ev.status_done = ev_status_done;
   end

   ep_hs_decode #(.DW(DW)) u_decode (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ev      (ev),
      .set_v   (set_v),
      .clr_v   (clr_v)
   );

   generate
      for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
         ep_hs_flag #(.SET_WINS(SET_WINS_MASK[gi])) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[gi]),
            .clr_i (clr_v[gi]),
            .q     (flags[gi])
         );
      end
   endgenerate

   ep_hs_rdmux #(.DW(DW)) u_rdmux (
      .flags   (flags),
      .rd_data (rd_data)
   );

   always_comb busy_o = flags[B_SETUPEND];
endmodule

// File: rtl/ctl_ep_hsreg_chk.sv
module ctl_ep_hsreg_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] rd_data,
   input logic          ev_rx_pkt,
   input logic          ev_tx_done,
   input logic          ev_proto_err,
   input logic          ev_early_end,
   input logic          ev_status_done,
   input logic          busy_o
);
   assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_pkt |=> rd_data[0]);
   assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_rx_pkt && !(wr_en && wr_data[6])) |=> $stable(rd_data[0]));
   assert_rx_svc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[6] && !ev_rx_pkt) |=> !rd_data[0]);
   assert_tx_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_done && !(wr_en && wr_data[1])) |=> !rd_data[1]);
   assert_stall_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[2] == $past(wr_data[2])));
   assert_dataend_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_status_done && !(wr_en && wr_data[3])) |=> !rd_data[3]);
   assert_fstall_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_proto_err |=> rd_data[4]);
   assert_setupend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_early_end |=> rd_data[5]);
   assert_strobes_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00);
   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == rd_data[5]);
endmodule

bind ctl_ep_hsreg ctl_ep_hsreg_chk #(.DW(DW)) u_chk (.*);

// File: tb/ctl_ep_hsreg_bench.sv
module ctl_ep_hsreg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [4:0] ev = '0; // [0]rx [1]tx [2]proto [3]early [4]status
   logic       busy_o;

   int checks = 0;
   int errors = 0;
   logic [5:0] m = '0; // reference flags
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   ctl_ep_hsreg u_ctl_ep_hsreg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ev_rx_pkt(ev[0]), .ev_tx_done(ev[1]),
      .ev_proto_err(ev[2]), .ev_early_end(ev[3]), .ev_status_done(ev[4]),
      .busy_o(busy_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] model(input logic [5:0] c, input logic w,
                                        input logic [7:0] d, input logic [4:0] e);
      logic [5:0] n;
      n[0] = e[0] ? 1'b1 : ((w && d[6]) ? 1'b0 : c[0]);   // R2, R9
      n[1] = (w && d[1]) ? 1'b1 : (e[1] ? 1'b0 : c[1]);   // R3
      n[2] = w ? d[2] : c[2];                             // R4
      n[3] = (w && d[3]) ? 1'b1 : (e[4] ? 1'b0 : c[3]);   // R5
      n[4] = e[2] ? 1'b1 : ((w && !d[4]) ? 1'b0 : c[4]);  // R6, R9
      n[5] = e[3] ? 1'b1 : ((w && d[7]) ? 1'b0 : c[5]);   // R7, R9
      return n;
   endfunction

   task automatic compare_all();
      chk("R2 rx-ready",    {7'b0, rd_data[0]}, {7'b0, m[0]});
      chk("R3 tx-ready",    {7'b0, rd_data[1]}, {7'b0, m[1]});
      chk("R4 stall-req",   {7'b0, rd_data[2]}, {7'b0, m[2]});
      chk("R5 data-end",    {7'b0, rd_data[3]}, {7'b0, m[3]});
      chk("R6 forced-stall",{7'b0, rd_data[4]}, {7'b0, m[4]});
      chk("R7 setup-end",   {7'b0, rd_data[5]}, {7'b0, m[5]});
      chk("R8 strobes",     {6'b0, rd_data[7:6]}, 8'h00);
      chk("R11 busy",       {7'b0, busy_o}, {7'b0, m[5]});
   endtask

   // inputs driven at negedge; result sampled at the following negedge
   task automatic step(input logic w, input logic [7:0] d, input logic [4:0] e);
      wr_en = w; wr_data = d; ev = e;
      @(negedge clk);
      m = model(m, w, d, e);
      compare_all();
      wr_en = 1'b0; wr_data = '0; ev = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset read", rd_data, 8'h00);
      chk("R1 reset busy", {7'b0, busy_o}, 8'h00);

      // R9: set events collide with serviced/firmware clears
      step(1'b0, 8'h00, 5'b01101);                 // rx, proto, early set
      chk("R9 setup", rd_data, 8'h31);
      step(1'b1, 8'hC0, 5'b01101);                 // clears vs sets, set wins
      chk("R9 set beats clear", rd_data, 8'h31);

      // R10: one write: svc both strobes, set tx/data-end/stall, keep fstall
      step(1'b1, 8'hDE, 5'b00000);
      chk("R10 combined write", rd_data, 8'h1E);
      // R3/R5 write wins over hardware clear in the same cycle
      step(1'b1, 8'h0A, 5'b10010);
      chk("R3 R5 write wins", rd_data, 8'h0A);
      step(1'b0, 8'h00, 5'b10010);
      chk("R3 R5 hw clear", rd_data, 8'h00);

      // near-exhaustive sweep: all write data x strobe x event patterns
      for (int i = 0; i < 16384; i++) begin
         logic [13:0] v;
         v = 14'(i);
         step(v[13] ^ v[2], v[7:0], v[12:8]);
      end

      // reset again mid-run (R1)
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m = '0;
      chk("R1 re-reset read", rd_data, 8'h00);
      finish_run();
   end
endmodule